// File: doc/BRIEF.md
# Next-N Trace Correlation Trainer

This block sits at the commit end of a trace-based front end. It learns which trace tends to be committed a fixed number of commits (the prefetch distance N) after a given trace. It keeps a short shift history of the last N+1 committed traces. Each history slot records the trace identifier, which of the two next-trace predictor tables produced that trace's successor prediction, and the row of that table that was used. On every commit the history advances. The row named by the oldest slot is then trained with the identifier of the trace that has just committed.

Each predictor row carries a prefetch target identifier and a 3-bit confidence counter. Confidence rises slowly on agreement and falls fast on disagreement. When confidence is low, the stored target is replaced. The fetch side reads the same two tables through a separate port, alongside the normal next-trace prediction. It turns a row with non-zero confidence into a prefetch request for the stored target. Both tables are modelled here as small register arrays. Prediction and index hashing lie outside the block.

Top module: `ntrace_corr_updater`

## Requirements
- R1: After reset every row of both tables holds target 0 and confidence 0, and `pf_valid` is low. A fetch after reset therefore issues no prefetch.
- R2: A commit (`cm_valid` high at a clock edge) moves every history slot one step toward the oldest and stores the committing trace's identifier, selector and index as newest. The row then trained is the one recorded N commits earlier, and the committing identifier is the training target.
- R3: No row is trained until N+1 commits have been seen since reset. With N=2, the commits id0@(0,0), id1@(1,1), id0@(0,0) leave row (0,0) at target 0 with confidence 1. A fetch of row (0,0) issues no prefetch after only the first two commits.
- R4: When the training target equals the stored target, confidence increases by 1 and saturates at 7.
- R5: When the target differs and confidence is above 4, confidence drops by 4 and the stored target is kept.
- R6: When the target differs and confidence is 4 or less, confidence becomes 0 and the stored target is replaced by the training target.
- R7: A fetch (`fe_valid` high at an edge) on row (`fe_sel`, `fe_idx`) raises `pf_valid` after that edge exactly when the row's confidence is 1 or more. `pf_id` carries the stored target and `pf_cnt` the confidence. Without a fetch, `pf_valid` is low.
- R8: Selector 0 addresses the correlated table and selector 1 the alternate table. Training one table never alters the same index in the other.
- R9: While `cm_valid` is low, the commit inputs are ignored: the history does not move and no row is trained.
- R10: A training write from a commit at edge c lands at edge c+1, through a port separate from fetch. A fetch sampled at edge c+1 returns the row's previous contents, and a fetch sampled at edge c+2 returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_valid | input | 1 | A trace commits this cycle |
| cm_id | input | ID_W | Identifier of the committing trace |
| cm_sel | input | 1 | Table that predicted this trace's successor (0 correlated, 1 alternate) |
| cm_idx | input | IDX_W | Row of that table used for the prediction |
| fe_valid | input | 1 | Fetch-side table read this cycle |
| fe_sel | input | 1 | Table read by the fetch side |
| fe_idx | input | IDX_W | Row read by the fetch side |
| pf_valid | output | 1 | Prefetch request issued (registered) |
| pf_id | output | ID_W | Trace identifier to prefetch |
| pf_cnt | output | 3 | Confidence read with the request |

## Verification
The bench builds the block with N=2, 8-row tables and 4-bit identifiers. Short repeating commit patterns then drive a row through the whole counter range within a few dozen commits. The narrow identifier and index spaces make random streams collide on rows often, so mismatch replacement and cross-table independence are exercised frequently. The directed part walks one row from 0 up to saturation, down by 4, down to zero with target replacement, and back up again. It also checks the read-before-write timing between a training write and a concurrent fetch.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  localparam int CONF_W = 3;
  typedef logic [CONF_W-1:0] conf_t;
  localparam conf_t CONF_MAX  = 3'd7;
  localparam conf_t CONF_STEP = 3'd4;
  localparam int NUM_TBL = 2;
endpackage

// File: rtl/ntc_history.sv
module ntc_history #(
  parameter int ID_W  = 8,
  parameter int IDX_W = 4,
  parameter int DIST  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [ID_W-1:0]  in_id,
  input  logic             in_sel,
  input  logic [IDX_W-1:0] in_idx,
  output logic             trn_v,
  output logic             trn_sel,
  output logic [IDX_W-1:0] trn_idx,
  output logic [ID_W-1:0]  trn_src_id
);
  localparam int SLOTS = DIST + 1;
  localparam int FW    = $clog2(SLOTS) + 1;

  logic [ID_W-1:0]  h_id  [SLOTS];
  logic             h_sel [SLOTS];
  logic [IDX_W-1:0] h_idx [SLOTS];
  logic [FW-1:0]    seen;
  logic             full_before;

  // DIST commits already held means this push fills all DIST+1 slots
  assign full_before = (seen == FW'(DIST));

  // slot 1 becomes the oldest slot once this push shifts the buffer
  assign trn_v      = push && full_before;
  assign trn_sel    = h_sel[1];
  assign trn_idx    = h_idx[1];
  assign trn_src_id = h_id[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        h_id[i]  <= '0;
        h_sel[i] <= 1'b0;
        h_idx[i] <= '0;
      end
    end else if (push) begin
      for (int i = 0; i < DIST; i++) begin
        h_id[i]  <= h_id[i+1];
        h_sel[i] <= h_sel[i+1];
        h_idx[i] <= h_idx[i+1];
      end
      h_id[DIST]  <= in_id;
      h_sel[DIST] <= in_sel;
      h_idx[DIST] <= in_idx;
      if (!full_before) seen <= seen + 1'b1;
    end
  end
endmodule

// File: rtl/ntc_conf_calc.sv
module ntc_conf_calc
  import ntc_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] cur_tgt,
  input  conf_t           cur_cnt,
  input  logic [ID_W-1:0] obs_id,
  output logic [ID_W-1:0] nxt_tgt,
  output conf_t           nxt_cnt
);
  always_comb begin
    nxt_tgt = cur_tgt;
    nxt_cnt = cur_cnt;
    if (cur_tgt == obs_id) begin
      if (cur_cnt != CONF_MAX) nxt_cnt = cur_cnt + conf_t'(1);
    end else if (cur_cnt > CONF_STEP) begin
      nxt_cnt = cur_cnt - CONF_STEP;
    end else begin
      nxt_cnt = '0;
      nxt_tgt = obs_id;
    end
  end
endmodule

// File: rtl/ntc_table.sv
module ntc_table
  import ntc_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ID_W-1:0]  wr_tgt,
  input  conf_t            wr_cnt,
  input  logic [IDX_W-1:0] rmw_idx,
  output logic [ID_W-1:0]  rmw_tgt,
  output conf_t            rmw_cnt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ID_W-1:0]  rd_tgt,
  output conf_t            rd_cnt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ID_W-1:0] tgt_mem [DEPTH];
  conf_t           cnt_mem [DEPTH];

  // commit-side port: read for the update, write back next edge
  assign rmw_tgt = tgt_mem[rmw_idx];
  assign rmw_cnt = cnt_mem[rmw_idx];
  // fetch-side port: independent read
  assign rd_tgt  = tgt_mem[rd_idx];
  assign rd_cnt  = cnt_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        tgt_mem[i] <= '0;
        cnt_mem[i] <= '0;
      end
    end else if (wr_en) begin
      tgt_mem[wr_idx] <= wr_tgt;
      cnt_mem[wr_idx] <= wr_cnt;
    end
  end
endmodule

// File: rtl/ntrace_corr_updater.sv
module ntrace_corr_updater
  import ntc_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int IDX_W = 4,
  parameter int DIST  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cm_valid,
  input  logic [ID_W-1:0]  cm_id,
  input  logic             cm_sel,
  input  logic [IDX_W-1:0] cm_idx,
  input  logic             fe_valid,
  input  logic             fe_sel,
  input  logic [IDX_W-1:0] fe_idx,
  output logic             pf_valid,
  output logic [ID_W-1:0]  pf_id,
  output logic [2:0]       pf_cnt
);
  logic             trn_v;
  logic             trn_sel;
  logic [IDX_W-1:0] trn_idx;
  logic [ID_W-1:0]  trn_src_id;

  logic             req_v;
  logic             req_sel;
  logic [IDX_W-1:0] req_idx;
  logic [ID_W-1:0]  req_tgt;

  logic [ID_W-1:0]  rmw_tgt [NUM_TBL];
  conf_t            rmw_cnt [NUM_TBL];
  logic [ID_W-1:0]  rd_tgt  [NUM_TBL];
  conf_t            rd_cnt  [NUM_TBL];
  logic [ID_W-1:0]  new_tgt;
  conf_t            new_cnt;

  ntc_history #(.ID_W(ID_W), .IDX_W(IDX_W), .DIST(DIST)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .push       (cm_valid),
    .in_id      (cm_id),
    .in_sel     (cm_sel),
    .in_idx     (cm_idx),
    .trn_v      (trn_v),
    .trn_sel    (trn_sel),
    .trn_idx    (trn_idx),
    .trn_src_id (trn_src_id)
  );

  // stage the training request; the row is updated on the following edge
  always_ff @(posedge clk) begin
    if (rst) begin
      req_v   <= 1'b0;
      req_sel <= 1'b0;
      req_idx <= '0;
      req_tgt <= '0;
    end else begin
      req_v   <= trn_v;
      req_sel <= trn_sel;
      req_idx <= trn_idx;
      req_tgt <= cm_id;
    end
  end

  ntc_conf_calc #(.ID_W(ID_W)) u_calc (
    .cur_tgt (rmw_tgt[req_sel]),
    .cur_cnt (rmw_cnt[req_sel]),
    .obs_id  (req_tgt),
    .nxt_tgt (new_tgt),
    .nxt_cnt (new_cnt)
  );

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    ntc_table #(.ID_W(ID_W), .IDX_W(IDX_W)) u_tbl (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (req_v && (req_sel == 1'(g))),
      .wr_idx  (req_idx),
      .wr_tgt  (new_tgt),
      .wr_cnt  (new_cnt),
      .rmw_idx (req_idx),
      .rmw_tgt (rmw_tgt[g]),
      .rmw_cnt (rmw_cnt[g]),
      .rd_idx  (fe_idx),
      .rd_tgt  (rd_tgt[g]),
      .rd_cnt  (rd_cnt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_id    <= '0;
      pf_cnt   <= '0;
    end else begin
      pf_valid <= fe_valid && (rd_cnt[fe_sel] != '0);
      pf_id    <= rd_tgt[fe_sel];
      pf_cnt   <= rd_cnt[fe_sel];
    end
  end
endmodule

// File: rtl/ntc_checker.sv
module ntc_checker #(
  parameter int ID_W = 8,
  parameter int DIST = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            cm_valid,
  input logic [ID_W-1:0] cm_id,
  input logic            fe_valid,
  input logic            pf_valid,
  input logic [2:0]      pf_cnt,
  input logic            req_v,
  input logic [ID_W-1:0] trn_src_id
);
  localparam int CW = $clog2(DIST + 2) + 1;

  logic [CW-1:0]   ck_seen;
  logic [ID_W-1:0] ck_id [DIST+1];
  logic            rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      ck_seen <= '0;
      for (int i = 0; i <= DIST; i++) ck_id[i] <= '0;
    end else if (cm_valid) begin
      if (ck_seen != CW'(DIST + 1)) ck_seen <= ck_seen + 1'b1;
      for (int i = 0; i < DIST; i++) ck_id[i] <= ck_id[i+1];
      ck_id[DIST] <= cm_id;
    end
  end

  // R1: an edge taken in reset leaves no prefetch request
  always_ff @(posedge clk) begin
    if (rst_q) a_r1_reset_quiet: assert (!pf_valid);
  end

  // R3: training only after DIST+1 commits
  a_r3_no_early_train: assert property (@(posedge clk) disable iff (rst)
    req_v |-> (ck_seen == CW'(DIST + 1)));

  // R2: once the history is full, every commit produces a training request
  a_r2_train_follows_commit: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && (ck_seen >= CW'(DIST))) |=> req_v);

  // R2: the trained row belongs to the trace committed DIST commits earlier
  a_r2_source_distance: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && (ck_seen >= CW'(DIST))) |-> (trn_src_id == ck_id[1]));

  // R7: a request never carries zero confidence
  a_r7_pf_conf_nonzero: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_cnt != 3'd0));

  // R7: no request without a fetch read
  a_r7_pf_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    !fe_valid |=> !pf_valid);
endmodule

bind ntrace_corr_updater ntc_checker #(.ID_W(ID_W), .DIST(DIST)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cm_valid   (cm_valid),
  .cm_id      (cm_id),
  .fe_valid   (fe_valid),
  .pf_valid   (pf_valid),
  .pf_cnt     (pf_cnt),
  .req_v      (req_v),
  .trn_src_id (trn_src_id)
);

// File: tb/ntrace_corr_updater_tb_top.sv
module ntrace_corr_updater_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W  = 4;
  localparam int IDX_W = 3;
  localparam int DIST  = 2;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cm_valid = 1'b0;
  logic [ID_W-1:0]  cm_id = '0;
  logic             cm_sel = 1'b0;
  logic [IDX_W-1:0] cm_idx = '0;
  logic             fe_valid = 1'b0;
  logic             fe_sel = 1'b0;
  logic [IDX_W-1:0] fe_idx = '0;
  logic             pf_valid;
  logic [ID_W-1:0]  pf_id;
  logic [2:0]       pf_cnt;

  ntrace_corr_updater #(.ID_W(ID_W), .IDX_W(IDX_W), .DIST(DIST)) dut_i (
    .clk(clk), .rst(rst),
    .cm_valid(cm_valid), .cm_id(cm_id), .cm_sel(cm_sel), .cm_idx(cm_idx),
    .fe_valid(fe_valid), .fe_sel(fe_sel), .fe_idx(fe_idx),
    .pf_valid(pf_valid), .pf_id(pf_id), .pf_cnt(pf_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int m_tgt [2][DEPTH];
  int m_cnt [2][DEPTH];
  int h_sel [DIST+1];
  int h_idx [DIST+1];
  int fill;
  bit p_v;
  int p_sel, p_idx, p_tgt;
  bit e_v;
  int e_id, e_cnt;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < DEPTH; i++) begin
        m_tgt[t][i] = 0;
        m_cnt[t][i] = 0;
      end
    for (int i = 0; i <= DIST; i++) begin
      h_sel[i] = 0;
      h_idx[i] = 0;
    end
    fill = 0;
    p_v = 0;
  endtask

  function automatic int rule_cnt(input int cur_t, input int cur_c, input int obs);
    if (cur_t == obs) return (cur_c < 7) ? cur_c + 1 : 7;
    if (cur_c > 4) return cur_c - 4;
    return 0;
  endfunction

  task automatic model_edge(input bit cv, input int cid, input int csel, input int cidx,
                            input bit fv, input int fsel, input int fidx);
    e_v   = fv && (m_cnt[fsel][fidx] != 0);
    e_id  = m_tgt[fsel][fidx];
    e_cnt = m_cnt[fsel][fidx];
    if (p_v) begin
      int c;
      c = rule_cnt(m_tgt[p_sel][p_idx], m_cnt[p_sel][p_idx], p_tgt);
      if (m_tgt[p_sel][p_idx] != p_tgt && m_cnt[p_sel][p_idx] <= 4) m_tgt[p_sel][p_idx] = p_tgt;
      m_cnt[p_sel][p_idx] = c;
    end
    p_v = 0;
    if (cv) begin
      bit full;
      full = (fill >= DIST);
      for (int i = 0; i < DIST; i++) begin
        h_sel[i] = h_sel[i+1];
        h_idx[i] = h_idx[i+1];
      end
      h_sel[DIST] = csel;
      h_idx[DIST] = cidx;
      if (full) begin
        p_v = 1; p_sel = h_sel[0]; p_idx = h_idx[0]; p_tgt = cid;
      end else fill++;
    end
  endtask

  task automatic cyc(input bit cv, input int cid, input int csel, input int cidx,
                     input bit fv, input int fsel, input int fidx, input string tag);
    cm_valid = cv; cm_id = ID_W'(cid); cm_sel = csel[0]; cm_idx = IDX_W'(cidx);
    fe_valid = fv; fe_sel = fsel[0]; fe_idx = IDX_W'(fidx);
    @(posedge clk);
    model_edge(cv, cid, csel, cidx, fv, fsel, fidx);
    #1;
    check({tag, " pf_valid"}, int'(pf_valid), int'(e_v));
    if (e_v) begin
      check({tag, " pf_id"}, int'(pf_id), e_id);
      check({tag, " pf_cnt"}, int'(pf_cnt), e_cnt);
    end
  endtask

  task automatic commit(input int id, input int sel, input int idx);
    cyc(1, id, sel, idx, 0, 0, 0, "R2 commit");
  endtask

  task automatic fetch(input int sel, input int idx, input string tag);
    cyc(0, 0, 0, 0, 1, sel, idx, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cm_valid = 0; fe_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    model_reset();
    check("R1 pf_valid in reset", int'(pf_valid), 0);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog act=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R1: every row empty after reset
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < DEPTH; i++) fetch(t, i, "R1 empty after reset");

    // R3: training starts only at the third commit (N=2)
    commit(0, 0, 0);
    commit(1, 1, 1);
    fetch(0, 0, "R3 before fill");
    fetch(0, 0, "R3 before fill");
    check("R3 no early training", int'(pf_valid), 0);
    commit(0, 0, 0);
    fetch(0, 0, "R3 after fill");
    fetch(0, 0, "R3 after fill");
    check("R3 first training valid", int'(pf_valid), 1);
    check("R3 first training cnt", int'(pf_cnt), 1);
    check("R3 first training id", int'(pf_id), 0);

    // R1: reset clears the trained row
    do_reset();
    fetch(0, 0, "R1 cleared by reset");
    check("R1 row cleared", int'(pf_valid), 0);

    // R4: A(1,0,1) B(2,1,2) C(3,0,3) repeated; A learns C
    for (int r = 0; r < 5; r++) begin
      commit(1, 0, 1); commit(2, 1, 2); commit(3, 0, 3);
    end
    fetch(0, 1, "R4 climb");
    fetch(0, 1, "R4 climb");
    check("R4 cnt after 5 rounds", int'(pf_cnt), 4);
    check("R4 id after 5 rounds", int'(pf_id), 3);
    for (int r = 0; r < 4; r++) begin
      commit(1, 0, 1); commit(2, 1, 2); commit(3, 0, 3);
    end
    fetch(0, 1, "R4 saturate");
    fetch(0, 1, "R4 saturate");
    check("R4 saturated cnt", int'(pf_cnt), 7);

    // R5: A X(4,1,4) Y(5,0,5): mismatch from 7
    commit(1, 0, 1); commit(4, 1, 4); commit(5, 0, 5);
    fetch(0, 1, "R5 drop");
    fetch(0, 1, "R5 drop");
    check("R5 cnt 7 minus 4", int'(pf_cnt), 3);
    check("R5 target kept", int'(pf_id), 3);

    // R6: mismatch from 3 clears and replaces
    commit(1, 0, 1); commit(4, 1, 4); commit(5, 0, 5);
    fetch(0, 1, "R6 clear");
    fetch(0, 1, "R6 clear");
    check("R6 cleared no prefetch", int'(pf_valid), 0);
    commit(1, 0, 1); commit(4, 1, 4); commit(5, 0, 5);
    fetch(0, 1, "R6 replaced");
    fetch(0, 1, "R6 replaced");
    check("R6 new target", int'(pf_id), 5);
    check("R6 counts from zero", int'(pf_cnt), 1);

    // R8: tables are independent
    fetch(1, 1, "R8 other table");
    check("R8 alternate row 1 untouched", int'(pf_valid), 0);
    fetch(1, 2, "R8 alternate trained");
    check("R8 B target", int'(pf_id), 1);
    check("R8 B cnt", int'(pf_cnt), 7);
    fetch(0, 2, "R8 correlated row 2");
    check("R8 correlated row 2 untouched", int'(pf_valid), 0);
    fetch(1, 4, "R8 X row");
    check("R8 X cnt", int'(pf_cnt), 1);

    // R9: idle commit inputs ignored
    for (int k = 0; k < 4; k++) cyc(0, 9, 0, 1, 0, 0, 0, "R9 idle");
    commit(6, 1, 6);
    fetch(0, 1, "R9 idle");
    fetch(0, 1, "R9 idle");
    check("R9 A untouched cnt", int'(pf_cnt), 1);
    check("R9 A untouched id", int'(pf_id), 5);
    fetch(1, 4, "R9 X retrained");
    check("R9 X replaced", int'(pf_valid), 0);

    // R10: read-before-write between training and fetch
    commit(1, 0, 1); commit(4, 1, 4); commit(5, 0, 5);
    fetch(0, 1, "R10 same edge as write");
    check("R10 old contents", int'(pf_cnt), 1);
    fetch(0, 1, "R10 after write");
    check("R10 new contents", int'(pf_cnt), 2);

    // random phase: periodic streams with noise, random fetches
    do_reset();
    begin
      int pat [5] = '{7, 8, 9, 10, 11};
      int pos = 0;
      for (int n = 0; n < 4000; n++) begin
        bit cv, fv;
        int id, sel, idx;
        cv = ($urandom % 4) != 0;
        if ($urandom % 8 == 0) id = $urandom % 16;
        else begin id = pat[pos]; pos = (pos + 1) % 5; end
        sel = id % 2;
        idx = id % DEPTH;
        if ($urandom % 16 == 0) begin sel = $urandom % 2; idx = $urandom % DEPTH; end
        fv = ($urandom % 2) != 0;
        cyc(cv, id, sel, idx, fv, $urandom % 2, $urandom % DEPTH, "R7 random");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule